// File: doc/BRIEF.md
# Supply Voltage Monitor Interrupt Controller

This block is the digital back end of a supply-voltage monitor. An analog comparator outside the block reports whether the supply sits at or above a threshold. That asynchronous level is first synchronized. It is then either passed through a sampled majority-free noise filter or used directly. The filter accepts a new level only once several consecutive samples agree, and it samples on a selectable division of a low-speed clock-enable strobe.

When the resulting level crosses the threshold in the programmed direction, the block sets a sticky detection flag and emits a one-cycle interrupt pulse. This happens only while the interrupt is enabled and the detection circuit is switched on. All configuration and status live in a single byte-wide register. Software can change that register only while a separate protect-enable input is high. The same register shows a live monitor of the supply level.

The register is read combinationally on `reg_rdata_o` and written through a single-cycle strobe. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `vmon_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x8A. That value is: direction bit 7 = 1, bypass bit 1 = 1, monitor bit 3 = 1 with the supply high, enable bit 0 = 0, flag bit 2 = 0, divider bits 5:4 = 00. The interrupt output is low after reset.
- R2: A write strobe changes the register only when `wr_prot_en_i` is 1. While it is 0, bits 0, 1, 2, 4, 5 and 7 keep their values.
- R3: Flag bit 2 is sticky. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If a hardware set and a software clear land on the same clock edge, the flag ends up 1.
- R4: Bit 6 always reads 0. Bit 3 is read-only: it reads the selected supply level (1 = at or above threshold, 0 = below), and it reads 1 whenever `det_en_i` is 0.
- R5: With bit 1 = 1 (bypass), the selected level is the synchronized comparator. A comparator change driven before clock edge k produces its interrupt pulse in the cycle after edge k+2.
- R6: Bit 7 picks the crossing direction. With 0, a low-to-high change of the selected level is an event. With 1, a high-to-low change is an event.
- R7: An event raises `irq_o` for exactly one cycle and sets bit 2 on the same edge. This happens only when bit 0 = 1 and `det_en_i` = 1.
- R8: With bit 1 = 0 (filter), the filtered level takes a new value only when three consecutive samples agree on it. A low pulse of five cycles with samples spaced four cycles apart never causes an event.
- R9: Bits 5:4 select the sample rate as one sample per 1, 2, 4 or 8 strobes of `lsclk_en_i`, for codes 00, 01, 10 and 11. In filter mode, with one strobe every P cycles and a division N, a falling input yields its pulse between 2·N·P+2 and 3·N·P+5 cycles after the change.
- R10: The comparator passes through a two-flop synchronizer. Bit 3 shows a comparator change two clock edges after it is driven, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_async_i | input | 1 | Comparator output, 1 = supply at or above threshold, asynchronous |
| det_en_i | input | 1 | Detection circuit enabled |
| lsclk_en_i | input | 1 | One-cycle strobe per low-speed clock period |
| wr_prot_en_i | input | 1 | 1 permits register writes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A stale history in the filter or a divider that miscounts shows up at `irq_o`. The pulse arrives outside the window that the sample period sets: early by at least one sample period, or late by several. A wrong previous-level register yields a missing, extra or wrong-direction pulse within three cycles of a bypass-mode change. Flag bit 2 then disagrees on the very next read. A leaking write-protect gate or a mishandled flag clear is visible on the register readback one cycle after the write strobe.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned DIV_W   = 2;

  localparam int unsigned B_IE    = 0;
  localparam int unsigned B_BYP   = 1;
  localparam int unsigned B_FLAG  = 2;
  localparam int unsigned B_MON   = 3;
  localparam int unsigned B_DIV   = 4;
  localparam int unsigned B_RSV   = 6;
  localparam int unsigned B_DIR   = 7;

  typedef struct packed {
    logic             dir;
    logic [DIV_W-1:0] div;
    logic             byp;
    logic             ie;
  } vmon_cfg_t;

  localparam vmon_cfg_t CFG_RST = '{dir: 1'b1, div: '0, byp: 1'b1, ie: 1'b0};
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vmon_filter.sv
module vmon_filter #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  output logic             level_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] div_cnt_q;
  logic [CNT_W-1:0] div_mask;
  logic             sample_tick;
  logic [DEPTH-2:0] hist_q;
  logic [DEPTH-1:0] window;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) div_mask[i] = (i < int'(sel_i));
  end

  assign sample_tick = strobe_i && ((div_cnt_q & div_mask) == div_mask);
  assign window      = {hist_q, d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt_q <= '0;
    else if (strobe_i) div_cnt_q <= div_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '1;
      level_o <= 1'b1;
    end else if (sample_tick) begin
      hist_q <= window[DEPTH-2:0];
      if (&window) level_o <= 1'b1;
      else if (~|window) level_o <= 1'b0;
    end
  end

  // R8: the filtered level moves only on a sample tick
  a_r8_level_holds_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(level_o));
endmodule

// File: rtl/vmon_ctrl_reg.sv
module vmon_ctrl_reg
  import vmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             prot_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_set_i,
  input  logic             mon_i,
  output vmon_cfg_t        cfg_o,
  output logic             flag_o,
  output logic [REG_W-1:0] rdata_o
);
  logic wr_ok;
  logic sw_clr;
  logic unused_wbits;

  assign wr_ok        = wr_i && prot_en_i;
  assign sw_clr       = wr_ok && !wdata_i[B_FLAG];
  assign unused_wbits = wdata_i[B_RSV] ^ wdata_i[B_MON];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= CFG_RST;
    end else if (wr_ok) begin
      cfg_o.ie  <= wdata_i[B_IE];
      cfg_o.byp <= wdata_i[B_BYP];
      cfg_o.div <= wdata_i[B_DIV +: DIV_W];
      cfg_o.dir <= wdata_i[B_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else flag_o <= hw_set_i || (flag_o && !sw_clr);
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[B_IE]            = cfg_o.ie;
    rdata_o[B_BYP]           = cfg_o.byp;
    rdata_o[B_FLAG]          = flag_o;
    rdata_o[B_MON]           = mon_i;
    rdata_o[B_DIV +: DIV_W]  = cfg_o.div;
    rdata_o[B_DIR]           = cfg_o.dir;
  end

  // R2: a locked write leaves the configuration untouched
  a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !prot_en_i) |=> $stable(cfg_o));
  // R3: a hardware set always lands, even against a clear
  a_r3_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_i |=> flag_o);
  // R3: writing 1 to the flag never sets it
  a_r3_write_one_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !hw_set_i) |=> !flag_o);
endmodule

// File: rtl/vmon_irq_ctrl.sv
module vmon_irq_ctrl
  import vmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_DEPTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_async_i,
  input  logic             det_en_i,
  input  logic             lsclk_en_i,
  input  logic             wr_prot_en_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  vmon_cfg_t cfg;
  logic      flag;
  logic      cmp_sync;
  logic      filt_level;
  logic      sel_level;
  logic      prev_level_q;
  logic      crossing;
  logic      event_fire;
  logic      monitor;

  vmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_async_i), .q_o(cmp_sync)
  );

  vmon_filter #(.DEPTH(FILT_DEPTH), .SEL_W(DIV_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .strobe_i(lsclk_en_i), .sel_i(cfg.div),
    .d_i(cmp_sync), .level_o(filt_level)
  );

  assign sel_level  = cfg.byp ? cmp_sync : filt_level;
  assign monitor    = det_en_i ? sel_level : 1'b1;
  assign crossing   = cfg.dir ? (prev_level_q && !sel_level)
                              : (!prev_level_q && sel_level);
  assign event_fire = crossing && cfg.ie && det_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level_q <= 1'b1;
      irq_o        <= 1'b0;
    end else begin
      prev_level_q <= sel_level;
      irq_o        <= event_fire;
    end
  end

  vmon_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .prot_en_i(wr_prot_en_i),
    .wdata_i(reg_wdata_i), .hw_set_i(event_fire), .mon_i(monitor),
    .cfg_o(cfg), .flag_o(flag), .rdata_o(reg_rdata_o)
  );

  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R7: every pulse is accompanied by the sticky flag
  a_r7_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);
  // R7: a pulse needs the enable bit and the detection circuit
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(det_en_i && cfg.ie));
  // R6: a pulse follows a level change in the programmed direction
  a_r6_direction: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (prev_level_q == !$past(cfg.dir)));
  // R4: monitor bit forced high while detection is off
  a_r4_monitor_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_i |-> reg_rdata_o[B_MON]);
endmodule

// File: tb/vmon_irq_ctrl_test.sv
module vmon_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b1;
  logic       det = 1'b1;
  logic       lsclk = 1'b0;
  logic       prot = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int ls_cnt = 0;
  localparam int LS_P = 4;

  always #2.5 clk = ~clk;

  vmon_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp), .det_en_i(det),
    .lsclk_en_i(lsclk), .wr_prot_en_i(prot), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(negedge clk) begin
    ls_cnt <= (ls_cnt == LS_P-1) ? 0 : ls_cnt + 1;
    lsclk  <= (ls_cnt == LS_P-1);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic exp_evt(logic prev, logic lvl, logic dir, logic ie, logic de);
    logic x;
    x = dir ? (prev && !lvl) : (!prev && lvl);
    return x && ie && de;
  endfunction

  function automatic logic [7:0] exp_rd(logic dir, logic [1:0] dv, logic mon, logic fl,
                                        logic byp, logic ie);
    return {dir, 1'b0, dv, mon, fl, byp, ie};
  endfunction

  task automatic wreg(input logic [7:0] d, input logic p);
    @(negedge clk);
    wr = 1'b1; wdata = d; prot = p;
    @(negedge clk);
    wr = 1'b0; prot = 1'b0;
  endtask

  task automatic count_irq(input int cyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic       m_dir, m_byp, m_ie, m_fl, m_lvl;
    logic [1:0] m_dv;
    int         cnt;
    void'($urandom(32'h5eed_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rdata, 8'h8A);
    chk("R1 irq low after reset", irq, 0);

    // R2: locked write ignored
    wreg(8'h31, 1'b0);
    chk("R2 locked write", rdata, 8'h8A);

    // R10 / R4: monitor latency through the synchronizer (bypass)
    @(negedge clk); cmp = 1'b0;
    @(negedge clk);
    chk("R10 monitor after one edge", rdata[3], 1);
    @(negedge clk);
    chk("R10 monitor after two edges", rdata[3], 0);
    det = 1'b0;
    @(negedge clk);
    chk("R4 monitor with detection off", rdata[3], 1);
    chk("R4 reserved bit reads 0", rdata[6], 0);
    det = 1'b1; cmp = 1'b1;
    repeat (4) @(negedge clk);

    // R5 / R3 / R7: bypass latency, set beats clear, single-cycle pulse
    wreg(8'b1000_0011, 1'b1);      // dir fall, bypass, enable, flag clear
    @(negedge clk); cmp = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 no pulse after two edges", irq, 0);
    wr = 1'b1; prot = 1'b1; wdata = 8'b1000_0011;
    @(negedge clk);
    wr = 1'b0; prot = 1'b0;
    chk("R5 pulse after third edge", irq, 1);
    chk("R3 hardware set wins over clear", rdata[2], 1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", irq, 0);
    wreg(8'b1000_0111, 1'b1);
    chk("R3 writing 1 keeps flag", rdata[2], 1);
    wreg(8'b1000_0011, 1'b1);
    chk("R3 writing 0 clears flag", rdata[2], 0);
    wreg(8'b1000_0111, 1'b1);
    chk("R3 writing 1 does not set", rdata[2], 0);
    cmp = 1'b1;
    count_irq(8, cnt);
    chk("R6 rising ignored when falling selected", cnt, 0);

    // R8 / R9: filter mode at each division
    for (int s = 0; s < 4; s++) begin
      int tt, n;
      tt = (1 << s) * LS_P;
      wreg({1'b1, 1'b0, 2'(s), 1'b0, 1'b0, 1'b0, 1'b1}, 1'b1);
      repeat (4 * tt + 8) @(negedge clk);
      cmp = 1'b0;
      n = 0;
      for (int i = 0; i < 4 * tt + 20; i++) begin
        @(negedge clk);
        n++;
        if (irq) break;
      end
      chk_rng($sformatf("R9 filter delay div code %0d", s), n, 2 * tt + 2, 3 * tt + 5);
      chk($sformatf("R8 flag after filtered event %0d", s), rdata[2], 1);
      cmp = 1'b1;
      repeat (4 * tt + 8) @(negedge clk);
      chk($sformatf("R8 filtered monitor back high %0d", s), rdata[3], 1);
    end

    // R8: short glitch rejected
    wreg(8'b1000_0001, 1'b1);
    repeat (40) @(negedge clk);
    cmp = 1'b0;
    repeat (5) @(negedge clk);
    cmp = 1'b1;
    count_irq(40, cnt);
    chk("R8 glitch rejected", cnt, 0);
    chk("R8 glitch leaves flag clear", rdata[2], 0);

    // random bypass phase with write protection and direction
    wreg(8'b1000_0010, 1'b1);
    m_dir = 1'b1; m_dv = 2'b00; m_byp = 1'b1; m_ie = 1'b0; m_fl = 1'b0; m_lvl = 1'b1;
    repeat (6) @(negedge clk);
    for (int it = 0; it < 60; it++) begin
      logic [7:0] d;
      logic       p, nl, ev;
      d = 8'($urandom());
      d[1] = 1'b1;
      p = 1'($urandom());
      wreg(d, p);
      if (p) begin
        m_dir = d[7]; m_dv = d[5:4]; m_ie = d[0];
        if (!d[2]) m_fl = 1'b0;
      end
      det = 1'($urandom());
      @(negedge clk);
      chk("R2 random readback", rdata,
          exp_rd(m_dir, m_dv, det ? m_lvl : 1'b1, m_fl, m_byp, m_ie));
      nl = 1'($urandom());
      ev = exp_evt(m_lvl, nl, m_dir, m_ie, det);
      cmp = nl;
      count_irq(6, cnt);
      chk(m_dir ? "R6 falling event count" : "R7 rising event count", cnt, int'(ev));
      m_lvl = nl;
      if (ev) m_fl = 1'b1;
      chk("R7 flag tracks events", rdata[2], m_fl);
      chk("R4 monitor tracks level", rdata[3], det ? m_lvl : 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule